// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block runs after a translation buffer misses. It takes the virtual page number of the miss and the kind of access that caused it. It then walks a two-level page table held in physical memory. The 20-bit virtual page number splits into an upper 10-bit index for the first-level table and a lower 10-bit index for the second-level table. The 12-bit page offset never reaches the walker.

The walker reads the first table from the root page number supplied by a base register. It uses the page number in the first-level entry to find the second table. Every word read goes out on a request/acknowledge port at a physical address; the walker applies no translation to its own reads. A walk ends with a one-cycle result. The result is either the leaf entry, ready for the buffer refill, or a page fault. A page fault also reports the level at which the entry was missing.

A leaf that exists but does not permit the requested access is flagged separately as a denial. Only one walk runs at a time.

Every table entry is 32 bits:

| Bits | Meaning |
|---|---|
| 0 | valid |
| 1 | read allowed |
| 2 | write allowed |
| 3 | user access allowed |
| 31..12 | physical page number |

Top module: `pt_walker`

## Requirements
- R1: On an accepted request, the first read goes to address {root_ppn, 12'h000} + req_vpn[19:10]*4.
- R2: root_ppn and the request fields are captured when the request is accepted. Later changes to these inputs do not affect the walk in progress.
- R3: When the first-level entry has bit 0 set, the second read goes to {entry[31:12], 12'h000} + req_vpn[9:0]*4.
- R4: mem_req stays high with a stable mem_addr until mem_ack is seen, for any latency. mem_rdata is used only in the cycle mem_ack is high.
- R5: A first-level entry with bit 0 clear ends the walk with resp_fault=1 and resp_level=0, and no second read is made.
- R6: A second-level entry with bit 0 clear ends the walk with resp_fault=1 and resp_level=1.
- R7: A valid second-level entry ends the walk with resp_fault=0, resp_level=1, and resp_pte equal to that entry.
- R8: resp_deny=1 when the leaf is valid but the access is not allowed. A read needs bit 1, a write (req_write=1) needs bit 2, and a user access (req_user=1) also needs bit 3. resp_deny is 0 on faults.
- R9: busy is high from the cycle after acceptance through the done cycle. Requests presented while busy is high are ignored.
- R10: After reset the walker is idle with busy, mem_req and done low. done is a single-cycle pulse per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_ppn | input | 20 | Page number of the first-level table (base register) |
| req_valid | input | 1 | Miss request, taken when idle |
| req_vpn | input | 20 | Virtual page number of the miss |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | 32 | Physical word address |
| mem_ack | input | 1 | Read data valid / request complete |
| mem_rdata | input | 32 | Read data word |
| done | output | 1 | One-cycle result strobe |
| resp_fault | output | 1 | Page fault (nonexistent entry) |
| resp_level | output | 1 | Level of the fault: 0 first, 1 second |
| resp_deny | output | 1 | Leaf valid but access not permitted |
| resp_pte | output | 32 | Leaf entry for the refill |

## Verification
The walker is driven with several kinds of walk:

- walks that complete, under two different roots;
- walks that stop at a missing first-level entry, including an entry with bit 0 clear but other bits set;
- walks that stop at a missing second-level entry;
- walks that reach valid leaves whose permissions refuse a read, a write or a user access.

Together these separate the fault level from the denial and confirm that an entry's existence depends only on bit 0.

Acknowledge latencies range from zero to seven wait cycles. Junk data sits on the data bus when there is no acknowledge, so a design that uses the data early is caught. While a walk runs, the bench keeps driving a conflicting request and a different root, which exposes any failure to ignore them or to latch the root at acceptance.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  parameter int PA_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PA_W-OFF_W-1:0]    root_ppn,
  input  logic                     req_valid,
  input  logic [2*IDX_W-1:0]       req_vpn,
  input  logic                     req_write,
  input  logic                     req_user,
  output logic                     busy,
  output logic                     mem_req,
  output logic [PA_W-1:0]          mem_addr,
  input  logic                     mem_ack,
  input  logic [PA_W-1:0]          mem_rdata,
  output logic                     done,
  output logic                     resp_fault,
  output logic                     resp_level,
  output logic                     resp_deny,
  output logic [PA_W-1:0]          resp_pte
);
  localparam int PPN_W = PA_W - OFF_W;
  localparam int VPN_W = 2 * IDX_W;
  localparam int B_V = 0, B_R = 1, B_W = 2, B_U = 3;

  typedef enum logic [1:0] {IDLE, LVL1, LVL2, RESP} st_t;
  st_t st;

  logic [VPN_W-1:0] vpn_q;
  logic             wr_q, usr_q;
  logic [PPN_W-1:0] base_q;
  logic [IDX_W-1:0] idx;
  logic             leaf_ok;

  assign idx      = (st == LVL1) ? vpn_q[VPN_W-1 -: IDX_W] : vpn_q[IDX_W-1:0];
  assign mem_addr = {base_q, {OFF_W{1'b0}}} + PA_W'({idx, 2'b00});
  assign mem_req  = (st == LVL1) || (st == LVL2);
  assign busy     = (st != IDLE);
  assign done     = (st == RESP);
  assign leaf_ok  = (wr_q ? mem_rdata[B_W] : mem_rdata[B_R]) && (!usr_q || mem_rdata[B_U]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= IDLE;
      vpn_q      <= '0;
      wr_q       <= 1'b0;
      usr_q      <= 1'b0;
      base_q     <= '0;
      resp_fault <= 1'b0;
      resp_level <= 1'b0;
      resp_deny  <= 1'b0;
      resp_pte   <= '0;
    end else begin
      case (st)
        IDLE: if (req_valid) begin
          st     <= LVL1;
          vpn_q  <= req_vpn;
          wr_q   <= req_write;
          usr_q  <= req_user;
          base_q <= root_ppn;
        end
        LVL1: if (mem_ack) begin
          if (mem_rdata[B_V]) begin
            base_q <= mem_rdata[PA_W-1:OFF_W];
            st     <= LVL2;
          end else begin
            st         <= RESP;
            resp_fault <= 1'b1;
            resp_level <= 1'b0;
            resp_deny  <= 1'b0;
            resp_pte   <= mem_rdata;
          end
        end
        LVL2: if (mem_ack) begin
          st         <= RESP;
          resp_fault <= !mem_rdata[B_V];
          resp_level <= 1'b1;
          resp_deny  <= mem_rdata[B_V] && !leaf_ok;
          resp_pte   <= mem_rdata;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module pt_walker_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic mem_req,
  input logic [31:0] mem_addr,
  input logic mem_ack,
  input logic done,
  input logic resp_fault,
  input logic resp_deny
);
  a_r4_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req);
  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> $stable(mem_addr));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  a_r9_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && req_valid |=> busy && mem_req);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !done);
  a_r8_deny_not_fault: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(resp_fault && resp_deny));
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .done(done),
  .resp_fault(resp_fault), .resp_deny(resp_deny)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [19:0] root_ppn = '0;
  logic req_valid = 1'b0;
  logic [19:0] req_vpn = '0;
  logic req_write = 1'b0, req_user = 1'b0;
  logic busy, mem_req, done, resp_fault, resp_level, resp_deny;
  logic [31:0] mem_addr, resp_pte;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .root_ppn(root_ppn), .req_valid(req_valid),
    .req_vpn(req_vpn), .req_write(req_write), .req_user(req_user),
    .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .done(done), .resp_fault(resp_fault),
    .resp_level(resp_level), .resp_deny(resp_deny), .resp_pte(resp_pte)
  );

  always #5 clk = ~clk;

  localparam int N = 13;
  logic [19:0] t_root [N];
  logic [19:0] t_vpn [N];
  bit t_wr [N];
  bit t_usr [N];
  int t_lat [N];
  logic [31:0] pmem [logic [31:0]];

  int nchk = 0, nfail = 0, cyc = 0, qi = 0, idle = 0, wcnt = 0, lat = 0, ph = 0;
  bit fin = 0;
  logic [31:0] ea, w, epte;
  logic [19:0] mvpn;
  bit mwr, musr, efault, elvl, edeny;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return pmem.exists(a) ? pmem[a] : 32'h0;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      cyc++;
      chk("R9 busy", {31'b0, busy}, {31'b0, ph != 0});
      chk("R4 mem_req", {31'b0, mem_req}, {31'b0, ph == 1 || ph == 2});
      chk("R10 done", {31'b0, done}, {31'b0, ph == 3});
      if (ph == 1) chk("R1 R2 R9 first-level address", mem_addr, ea);
      if (ph == 2) chk("R3 second-level address", mem_addr, ea);
      if (ph == 3) begin
        chk("R5 R6 fault", {31'b0, resp_fault}, {31'b0, efault});
        chk("R5 R6 level", {31'b0, resp_level}, {31'b0, elvl});
        chk("R8 deny", {31'b0, resp_deny}, {31'b0, edeny});
        if (!efault) chk("R7 leaf entry", resp_pte, epte);
      end
      mem_ack = 1'b0;
      mem_rdata = 32'hFFFF_FFFF;
      req_valid = 1'b0;
      if (ph == 1 || ph == 2) begin
        if (wcnt == lat) begin
          w = rd(ea);
          mem_ack = 1'b1;
          mem_rdata = w;
          wcnt = 0;
        end else wcnt++;
      end
      if (ph != 0) begin
        req_valid = 1'b1; req_vpn = 20'hFFFFF; req_write = 1'b1; req_user = 1'b1;
        root_ppn = 20'h0DEAD;
      end else if (qi < N) begin
        req_valid = 1'b1; req_vpn = t_vpn[qi]; req_write = t_wr[qi];
        req_user = t_usr[qi]; root_ppn = t_root[qi]; lat = t_lat[qi];
        qi++;
      end
      case (ph)
        0: if (req_valid) begin
          ph = 1; mvpn = req_vpn; mwr = req_write; musr = req_user; wcnt = 0;
          ea = root_ppn * 4096 + (req_vpn >> 10) * 4;
        end else if (qi == N) begin
          idle++;
          if (idle > 5) fin = 1;
        end
        1: if (mem_ack) begin
          if (w[0]) begin
            ph = 2;
            ea = {w[31:12], 12'h000} + (mvpn & 20'h3FF) * 4;
          end else begin
            ph = 3; efault = 1; elvl = 0; edeny = 0;
          end
        end
        2: if (mem_ack) begin
          ph = 3; efault = !w[0]; elvl = 1; epte = w;
          edeny = w[0] && ((mwr ? !w[2] : !w[1]) || (musr && !w[3]));
        end
        default: ph = 0;
      endcase
      if (cyc > 20000) begin
        nfail++; nchk++;
        $display("FAIL watchdog actual=%0d expected<20000", cyc);
        fin = 1;
      end
    end
  end

  initial begin
    pmem[32'h0010_0000 + 32'h001 * 4] = 32'h0020_0001;
    pmem[32'h0010_0000 + 32'h004 * 4] = 32'h0020_00FE;
    pmem[32'h0010_0000 + 32'h3FF * 4] = 32'h0030_0001;
    pmem[32'h0020_0000 + 32'h005 * 4] = 32'hABCD_E00F;
    pmem[32'h0020_0000 + 32'h006 * 4] = 32'h1234_5003;
    pmem[32'h0020_0000 + 32'h007 * 4] = 32'h5555_500E;
    pmem[32'h0020_0000 + 32'h008 * 4] = 32'h0F0F_0005;
    pmem[32'h0040_0000 + 32'h001 * 4] = 32'h0050_0001;
    pmem[32'h0050_0000 + 32'h005 * 4] = 32'h7777_700B;
    // R7 completes; R5 first-level faults; R6 second-level faults; R8 denials; R2 second root
    t_root = '{20'h00100, 20'h00100, 20'h00100, 20'h00100, 20'h00100, 20'h00100, 20'h00100,
               20'h00100, 20'h00100, 20'h00100, 20'h00400, 20'h00400, 20'h00100};
    t_vpn  = '{20'h00405, 20'h00405, 20'h00812, 20'h01005, 20'h00407, 20'h00406, 20'h00406,
               20'h00406, 20'h00408, 20'h00408, 20'h00405, 20'h00405, 20'hFFFFF};
    t_wr   = '{0, 1, 0, 0, 0, 1, 0, 0, 0, 1, 0, 1, 0};
    t_usr  = '{0, 1, 0, 0, 0, 0, 1, 0, 0, 0, 1, 1, 0};
    t_lat  = '{0, 3, 1, 2, 0, 1, 0, 4, 0, 0, 5, 0, 7};
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset busy", {31'b0, busy}, 32'h0);
    chk("R10 reset mem_req", {31'b0, mem_req}, 32'h0);
    chk("R10 reset done", {31'b0, done}, 32'h0);
    rst_n = 1'b1;
    wait (fin);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule